// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit data bus. The host hands it one access at a time: a word address, a write flag, write data and one enable bit per byte. The controller turns that access into a strobe sequence on the memory pins. Each phase of the sequence lasts a whole number of system clock cycles. That number is derived at elaboration from the memory's nanosecond timing limits and the clock period parameter: the ceiling of the limit divided by the period, and never less than one.

The host side is a valid/ready stream. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While an access is in flight `req_ready` stays low, and the host must hold its request, unchanged, until it is taken. Back-pressure is total: there is no queue, so the next request waits until the memory cycle time has run out. Read data returns on `rsp_rdata` with a one-cycle `rsp_valid` pulse. The response channel has no ready, and the host must accept the data in that cycle.

On the memory side the controller keeps the chip deselected between accesses. It never enables the memory's outputs while it drives the bus itself, and it leaves a clear cycle on each side of every output-enable window.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and between accesses, the memory is deselected: `mem_cs_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, all `mem_lane_n` bits 1, `mem_dq_oe`=0, and `req_ready`=1.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access's last phase has ended. A request held through back-pressure starts exactly one access. Request inputs that change while an access is busy do not affect the pins of that access.
- R3: A write starts in the cycle after acceptance with a pulse of WP cycles. During the pulse the memory is selected, `mem_we_n`=0, `mem_oe_n`=1, and the accepted address and data are driven. WP is the largest of ceil(40/CLK_NS), ceil(25/CLK_NS) and ceil(40/CLK_NS), which is 2 at 20 ns.
- R4: After the pulse, a write recovery of WR = max(ceil(55/CLK_NS) - WP, 1) cycles follows (1 at 20 ns). In it the memory is deselected, `mem_we_n` is 1, and the write data is still driven.
- R5: During a write pulse and a read, `mem_lane_n[0]` is low exactly when byte enable bit 0 is set, and it governs data bits 7:0. `mem_lane_n[1]` does the same for bit 1 and data bits 15:8. A byte whose enable is clear is left unchanged in memory. A write with no enable bits set changes nothing.
- R6: A read holds the memory selected for one cycle with `mem_oe_n`=1 and the bus released. Output enable is then low for RD = max(ceil(55/CLK_NS) - 1, ceil(25/CLK_NS)) cycles (2 at 20 ns). The address stays stable throughout.
- R7: Read data is sampled from `mem_dq_i` at the end of the last output-enable cycle. It is presented with `rsp_valid`=1 for exactly the following cycle, in which the memory is deselected. Bytes whose enable is clear read as zero.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It is 0 in the cycle before `mem_oe_n` falls and in the cycle `mem_oe_n` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_be | input | LANES (2) | Byte enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W (16) | Read data, disabled bytes zero |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lane_n | output | LANES (2) | Active-low byte strobes, bit 0 = lower byte |
| mem_addr | output | ADDR_W (20) | Memory address |
| mem_dq_o | output | DATA_W (16) | Data driven toward memory |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W (16) | Data returned by memory |

## Verification
A phase counter loaded with the wrong length shows up on the memory pins within a single access. The write pulse, the recovery or the output-enable window comes out too short or too long in the very cycle the phase should have ended, and `req_ready` returns early or late. A faulty sampling point is caught at the `rsp_valid` cycle, because the bench memory only presents real data once output enable has been low for RD cycles. A wrong byte-lane state either shows on `mem_lane_n` during the access or corrupts memory contents that a later read returns. A turnaround fault shows as `mem_dq_oe` overlapping or touching the output-enable window.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WPULSE = 3'd1,
    PH_WREC   = 3'd2,
    PH_RGAP   = 3'd3,
    PH_RACC   = 3'd4,
    PH_REND   = 3'd5
  } phase_e;

  // active-high internal pin intents, inverted at the pins where needed
  typedef struct packed {
    logic sel;
    logic we;
    logic oe;
    logic lanes;
    logic drive;
  } pin_ctl_t;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_ctl_t phase_pins(input phase_e ph);
    pin_ctl_t p;
    p = '0;
    unique case (ph)
      PH_WPULSE: begin p.sel = 1'b1; p.we = 1'b1; p.lanes = 1'b1; p.drive = 1'b1; end
      PH_WREC:   begin p.drive = 1'b1; end
      PH_RGAP:   begin p.sel = 1'b1; p.lanes = 1'b1; end
      PH_RACC:   begin p.sel = 1'b1; p.oe = 1'b1; p.lanes = 1'b1; end
      default:   p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

  // every phase lasts at least one cycle (R3, R6)
  p_phase_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/asram_byte_lanes.sv
module asram_byte_lanes #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_on_d,
  input  logic [LANES-1:0]  be_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [LANES-1:0]  strobe_n,
  output logic [DATA_W-1:0] rdata
);

  logic [LANES-1:0] be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) be_q <= '0;
    else        be_q <= be_d;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              stb_n_q;
    logic [LANE_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_n_q <= 1'b1;
      else        stb_n_q <= !(strobe_on_d && be_d[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (capture) byte_q <= be_q[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end

    assign strobe_n[g]                 = stb_n_q;
    assign rdata[g*LANE_W +: LANE_W]   = byte_q;
  end

endmodule

// File: rtl/asram_dq_drive.sv
module asram_dq_drive #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_d,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end else begin
      if (load) dq_o <= wdata;
      dq_oe <= drive_d;
    end
  end

  // write data must not move while it is on the bus (R3, R4)
  p_dq_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int LANES    = 2,
  parameter int LANE_W   = 8,
  parameter int CLK_NS   = 20,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 40,
  parameter int T_DS_NS  = 25,
  parameter int T_AW_NS  = 40,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 25,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  // phase lengths in clock cycles
  localparam int N_WP   = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                               ns_to_cyc(T_AW_NS, CLK_NS));
  localparam int N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int N_WREC = imax(N_WC - N_WP, 1);
  localparam int N_RD   = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS) - 1, ns_to_cyc(T_OE_NS, CLK_NS)), 1);
  localparam int N_MAX  = imax(imax(N_WP, N_WREC), N_RD);
  localparam int CNT_W  = $clog2(N_MAX + 1);

  phase_e            ph_q, ph_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              ph_last;
  logic              accept;
  logic              capture;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [LANES-1:0]  be_d;
  pin_ctl_t          ctl_d, ctl_q;
  logic              rsp_valid_q;

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (ph_q == PH_RACC) && ph_last;

  // phase sequencing
  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (ph_q)
      PH_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          ph_d    = PH_WPULSE;
          tmr_val = CNT_W'(N_WP);
        end else begin
          ph_d    = PH_RGAP;
          tmr_val = CNT_W'(1);
        end
      end
      PH_WPULSE: if (ph_last) begin
        ph_d     = PH_WREC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_WREC);
      end
      PH_WREC: if (ph_last) ph_d = PH_IDLE;
      PH_RGAP: if (ph_last) begin
        ph_d     = PH_RACC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_RD);
      end
      PH_RACC: if (ph_last) begin
        ph_d     = PH_REND;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(1);
      end
      PH_REND: if (ph_last) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (ph_last)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      be_q   <= req_be;
    end
  end

  assign be_d = accept ? req_be : be_q;

  // registered pin controls, glitch-free at the memory
  assign ctl_d = phase_pins(ph_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign mem_cs_n = !ctl_q.sel;
  assign mem_cs2  = ctl_q.sel;
  assign mem_we_n = !ctl_q.we;
  assign mem_oe_n = !ctl_q.oe;
  assign mem_addr = addr_q;

  asram_byte_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_on_d (ctl_d.lanes),
    .be_d        (be_d),
    .capture     (capture),
    .dq_i        (mem_dq_i),
    .strobe_n    (mem_lane_n),
    .rdata       (rsp_rdata)
  );

  asram_dq_drive #(.DATA_W(DATA_W)) u_dq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && req_write),
    .wdata   (req_wdata),
    .drive_d (ctl_d.drive),
    .dq_o    (mem_dq_o),
    .dq_oe   (mem_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= capture;
  end

  assign rsp_valid = rsp_valid_q;

  // ---------------- checks ----------------
  int we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= 0;
    else if (!mem_we_n) we_run <= we_run + 1;
    else                we_run <= 0;
  end

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_busy_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n || mem_dq_oe || rsp_valid) |-> !req_ready);

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == N_WP));

  p_oe_off_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_cs_n));

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_contend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_gap_before_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

  localparam int CLK_NS = 20;
  localparam int ADDR_W = 20;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WP  = (cdiv(40) > cdiv(25)) ? cdiv(40) : cdiv(25);
  localparam int WR  = ((cdiv(55) - WP) < 1) ? 1 : (cdiv(55) - WP);
  localparam int RD  = ((cdiv(55) - 1) > cdiv(25)) ? (cdiv(55) - 1) : cdiv(25);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic [LANES-1:0]  req_be = '0;
  logic              rsp_valid;
  logic [DW-1:0]     rsp_rdata;
  logic              mem_cs_n, mem_cs2, mem_we_n, mem_oe_n;
  logic [LANES-1:0]  mem_lane_n;
  logic [ADDR_W-1:0] mem_addr;
  logic [DW-1:0]     mem_dq_o;
  logic              mem_dq_oe;
  logic [DW-1:0]     mem_dq_i = '0;

  always #(CLK_NS/2) clk = ~clk;

  asram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // expected per-cycle pin state: 0 idle, 1 wpulse, 2 wrec, 3 rgap, 4 racc, 5 rend
  typedef struct {
    int                ph;
    logic [LANES-1:0]  be;
    logic [DW-1:0]     wd;
    logic [ADDR_W-1:0] a;
  } exp_t;

  exp_t          eq[$];
  logic [DW-1:0] rdq[$];
  string         rtag[$];
  logic [DW-1:0] chip [logic [ADDR_W-1:0]];
  logic [DW-1:0] gold [logic [ADDR_W-1:0]];
  int checks = 0;
  int fails  = 0;
  int oe_run = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rd_map(input logic [DW-1:0] m [logic [ADDR_W-1:0]],
                                           input logic [ADDR_W-1:0] a);
    return m.exists(a) ? m[a] : '0;
  endfunction

  task automatic cycle_check();
    exp_t e;
    bit sel, we, oe, drv, rdy, rv;
    logic [LANES-1:0] lanes_n;
    string r;
    logic [DW-1:0] x;
    if (eq.size() > 0) e = eq.pop_front();
    else begin e.ph = 0; e.be = '0; e.wd = '0; e.a = '0; end
    sel = (e.ph == 1) || (e.ph == 3) || (e.ph == 4);
    we  = (e.ph == 1);
    oe  = (e.ph == 4);
    drv = (e.ph == 1) || (e.ph == 2);
    rdy = (e.ph == 0);
    rv  = (e.ph == 5);
    lanes_n = sel ? ~e.be : '1;
    case (e.ph)
      0: r = "R1";
      1: r = "R3";
      2: r = "R4";
      5: r = "R7";
      default: r = "R6";
    endcase
    chk((mem_cs_n == !sel) && (mem_cs2 == sel), r, "select", {mem_cs_n, mem_cs2}, {!sel, sel});
    chk(mem_we_n == !we, r, "we_n", mem_we_n, !we);
    chk(mem_oe_n == !oe, r, "oe_n", mem_oe_n, !oe);
    chk(mem_lane_n == lanes_n, "R5", "lane_n", mem_lane_n, lanes_n);
    chk(mem_dq_oe == drv, "R8", "dq_oe", mem_dq_oe, drv);
    chk(req_ready == rdy, "R2", "ready", req_ready, rdy);
    chk(rsp_valid == rv, "R7", "rsp_valid", rsp_valid, rv);
    if (sel) chk(mem_addr == e.a, r, "addr", mem_addr, e.a);
    if (drv) chk(mem_dq_o == e.wd, r, "dq_o", mem_dq_o, e.wd);
    if (rv && rdq.size() > 0) begin
      x = rdq.pop_front();
      r = rtag.pop_front();
      chk(rsp_rdata == x, r, "rdata", rsp_rdata, x);
    end
  endtask

  // behavioural memory: data only valid once output enable has been low RD cycles
  task automatic mem_step();
    bit selected;
    logic [DW-1:0] w;
    selected = !mem_cs_n && mem_cs2;
    if (selected && !mem_we_n) begin
      w = rd_map(chip, mem_addr);
      for (int l = 0; l < LANES; l++)
        if (!mem_lane_n[l]) w[l*LANE_W +: LANE_W] = mem_dq_o[l*LANE_W +: LANE_W];
      chip[mem_addr] = w;
    end
    if (selected && mem_we_n && !mem_oe_n) oe_run++;
    else oe_run = 0;
    if (oe_run == 0) mem_dq_i = '0;
    else if (oe_run < RD) mem_dq_i = 16'hDEAD;
    else begin
      w = rd_map(chip, mem_addr);
      for (int l = 0; l < LANES; l++)
        if (mem_lane_n[l]) w[l*LANE_W +: LANE_W] = 8'hEE;
      mem_dq_i = w;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cycle_check();
    mem_step();
  endtask

  task automatic do_op(input bit w, input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                       input logic [LANES-1:0] be, input string tag);
    exp_t e;
    logic [DW-1:0] g;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_be    = be;
    while (!req_ready) tick();   // R2: request held under back-pressure
    e.be = be; e.wd = d; e.a = a;
    if (w) begin
      e.ph = 1; for (int i = 0; i < WP; i++) eq.push_back(e);
      e.ph = 2; for (int i = 0; i < WR; i++) eq.push_back(e);
      g = rd_map(gold, a);
      for (int l = 0; l < LANES; l++)
        if (be[l]) g[l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      gold[a] = g;
    end else begin
      e.ph = 3; eq.push_back(e);
      e.ph = 4; for (int i = 0; i < RD; i++) eq.push_back(e);
      e.ph = 5; eq.push_back(e);
      g = rd_map(gold, a);
      for (int l = 0; l < LANES; l++)
        if (!be[l]) g[l*LANE_W +: LANE_W] = '0;
      rdq.push_back(g);
      rtag.push_back(tag);
    end
    tick();
    req_valid = 1'b0;
    req_addr  = ~a;          // R2: later changes must not reach the pins
    req_wdata = ~d;
    req_be    = ~be;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();                                  // R1 reset state
    do_op(1'b1, 20'h00010, 16'hA5C3, 2'b11, "R3");
    do_op(1'b0, 20'h00010, 16'h0000, 2'b11, "R7");
    do_op(1'b1, 20'h00010, 16'h1122, 2'b01, "R5");     // low byte only
    do_op(1'b0, 20'h00010, 16'h0000, 2'b11, "R5");
    do_op(1'b1, 20'h00010, 16'h7700, 2'b10, "R5");     // high byte only
    do_op(1'b0, 20'h00010, 16'h0000, 2'b01, "R7");     // upper masked to zero
    do_op(1'b0, 20'h00010, 16'h0000, 2'b10, "R7");     // lower masked to zero
    do_op(1'b1, 20'h00010, 16'hFFFF, 2'b00, "R5");     // no lanes: no change
    do_op(1'b0, 20'h00010, 16'h0000, 2'b11, "R5");
    do_op(1'b0, 20'h00010, 16'h0000, 2'b00, "R7");     // no lanes read: zero
    do_op(1'b1, 20'hFFFFF, 16'h8001, 2'b11, "R3");
    do_op(1'b1, 20'h00000, 16'h7FFE, 2'b11, "R3");
    do_op(1'b0, 20'hFFFFF, 16'h0000, 2'b11, "R6");
    do_op(1'b0, 20'h00000, 16'h0000, 2'b11, "R6");
    do_op(1'b0, 20'h0ABCD, 16'h0000, 2'b11, "R7");     // never written
    for (int i = 0; i < 8; i++)
      do_op(1'b1, ADDR_W'(20'h40000 + i * 20'h111), DW'(i * 16'h1357 + 1), 2'b11, "R4");
    for (int i = 0; i < 8; i++)
      do_op(1'b0, ADDR_W'(20'h40000 + i * 20'h111), 16'h0000, 2'(i % 4), "R7");
    for (int i = 0; i < 4; i++) begin                  // read/write turnaround
      do_op(1'b0, 20'h40000, 16'h0000, 2'b11, "R8");
      do_op(1'b1, 20'h40000, DW'(16'hC0DE ^ i), 2'b11, "R8");
    end
    do_op(1'b0, 20'h40000, 16'h0000, 2'b11, "R8");
    repeat (6) tick();
    chk(eq.size() == 0 && rdq.size() == 0, "R2", "drained", eq.size(), 0);
    finish_run();
  end

endmodule